// File: doc/BRIEF.md
# ADC Mode and Calibration Sequencer

This block is the control engine behind a sigma-delta converter subsystem. Software writes one 8-bit mode word. A 3-bit operation field chooses power-down, idle, single conversion, continuous conversion, or one of four calibrations: self offset, self gain, system zero-scale and system full-scale. A 2-bit power field chooses normal, low-power or low-power-plus operation. Two single bits choose the precision reference and the input resistor path.

The modulator and digital filter are not part of this block. They appear only as a "converter cycle finished" strobe with a data word. The sequencer counts those strobes until the filter has settled. It then stores the settled word, either as a conversion result or in the offset or gain register of every enabled channel. After a one-shot operation it rewrites its own operation field to idle, which leaves the converter powered but held in reset.

Three status flags report what has happened: conversion ready, calibration ready and invalid power code. Reading the status clears them.

Top module: `adc_mode_sequencer`

## Requirements
- R1: After reset, mode_q is 0x00 (power-down), all status flags are 0, result_q and every offset register are 0, and every gain register holds GAIN_RST.
- R2: A write loads mode_q with {0, wr_data[6:0]} on the next clock edge, so bit 7 always reads as 0.
- R3: The operation field is mode_q[2:0]. For 000: pwr_on=0, ref_en=0, conv_rst=1, busy=0. For 011: pwr_on=1, ref_en=1, conv_rst=1, busy=0. For the codes 001, 010 and 1xx: pwr_on=1, ref_en=1, conv_rst=0, busy=1.
- R4: In single conversion (010), the strobe that completes the settle count captures cyc_data into result_q. It also sets conversion ready, pulses drdy_pulse for one cycle and changes mode_q[2:0] to 011. The settle count is N strobes after the write, with N=2 when chop_en=0 and N=3 when chop_en=1.
- R5: In continuous mode (001), the Nth strobe and every later strobe each update result_q, set conversion ready and pulse drdy_pulse. The operation field stays 001.
- R6: Self-offset calibration (100) takes N strobes. It loads the final word into the offset register of every channel i with chan_en[i]=1 and leaves the other channels unchanged. It sets calibration ready and conversion ready and returns the operation field to 011.
- R7: Self-gain calibration (110 is not this; the code is 101) takes 2N strobes. It loads the gain registers of the enabled channels, sets both ready flags and returns to 011.
- R8: System zero-scale calibration (110) always takes 3 strobes, whatever chop_en is. It loads the offset registers of the enabled channels, sets both ready flags and returns to 011.
- R9: System full-scale calibration (111) takes N strobes. It loads the gain registers of the enabled channels, sets both ready flags and returns to 011.
- R10: The power field is mode_q[4:3]. gain_fix is 0 for 00 (free gain), 1 for 01 (gain 128) and 2 for 10 (gain 512). Code 11 behaves as 00, and writing it sets the invalid-power flag. With the reference on:
  - prec_ref_en = 1 in normal mode, or when mode_q[5]=1.
  - lp_ref_en = 1 in a low-power mode when mode_q[5]=0.
  - res_sel always equals mode_q[6].
- R11: A write made while an operation is running aborts that operation and discards its partial count. The new mode counts strobes from zero, and the aborted operation stores no result.
- R12: status_q is {invalid_power, cal_ready, conv_ready}. A cycle with rd_en=1 shows the flags and clears them at that edge. An event that sets a flag in the same cycle takes priority over the clear.
- R13: In power-down and idle, strobes are ignored. No register changes and drdy_pulse stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Mode register write strobe |
| wr_data | input | 8 | Mode word to write |
| rd_en | input | 1 | Status read; clears the flags |
| chop_en | input | 1 | Chop setting: 1 gives a 3-cycle settle, 0 gives 2 |
| chan_en | input | NCH | Channel enables for calibration loads |
| cyc_done | input | 1 | Converter cycle finished strobe |
| cyc_data | input | DW | Filter output word for that cycle |
| mode_q | output | 8 | Mode register contents |
| status_q | output | 3 | {invalid_power, cal_ready, conv_ready} |
| pwr_on | output | 1 | Converter powered |
| ref_en | output | 1 | Reference enabled |
| conv_rst | output | 1 | Converter held in reset |
| prec_ref_en | output | 1 | Precision reference selected |
| lp_ref_en | output | 1 | Low-power reference selected |
| res_sel | output | 1 | Resistor input path selected |
| gain_fix | output | 2 | Forced gain: 0 free, 1 x128, 2 x512 |
| busy | output | 1 | Conversion or calibration active |
| drdy_pulse | output | 1 | One-cycle pulse per stored conversion |
| result_q | output | DW | Last conversion result |
| off_q | output | NCH*DW | Offset registers, channel 0 in the low bits |
| gain_q | output | NCH*DW | Gain registers, channel 0 in the low bits |

## Verification
The assertions assume a few things about the inputs:
- cyc_done is a single-cycle pulse.
- chop_en is not changed while a settle count is running.
- A write that coincides with a completing strobe aborts it.

The stimulus honours these assumptions. It changes chop_en and chan_en only together with a mode write. It raises cyc_done for exactly one cycle per strobe, with random idle gaps between strobes. It never drives wr_en and cyc_done in the same cycle. Random mode words, chop settings, channel masks and data words are mixed with directed cases: an abort in mid-count, the undefined power code, and strobes in power-down and idle.

// File: rtl/adc_seq_pkg.sv
`timescale 1ns/1ps
// Package: shared encodings for the ADC mode sequencer.
// Assumes: operation field is 3 bits, power field 2 bits.
package adc_seq_pkg;

    typedef enum logic [2:0] {
        OP_PWRDN  = 3'b000,
        OP_CONT   = 3'b001,
        OP_SINGLE = 3'b010,
        OP_IDLE   = 3'b011,
        OP_SOFF   = 3'b100,
        OP_SGAIN  = 3'b101,
        OP_ZERO   = 3'b110,
        OP_FULL   = 3'b111
    } op_e;

    typedef enum logic [1:0] {
        PM_NORMAL  = 2'b00,
        PM_LOW     = 2'b01,
        PM_LOWPLUS = 2'b10,
        PM_UNDEF   = 2'b11
    } pmode_e;

    // True when the operation runs the converter (not power-down or idle).
    function automatic logic op_active(op_e op);
        return (op != OP_PWRDN) && (op != OP_IDLE);
    endfunction

endpackage

// File: rtl/adc_mode_reg.sv
`timescale 1ns/1ps
// Module: adc_mode_reg
// Holds the 8-bit mode word and decodes its fields. A software write
// replaces the word (bit 7 forced to 0). The end of a one-shot operation
// rewrites the operation field to idle. Assumes a write and a one-shot
// completion never land together (the top gates completion with wr_en).
module adc_mode_reg
    import adc_seq_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_en,
    input  logic [7:0] wr_data,
    input  logic       oneshot_done,
    output logic [7:0] mode_q,
    output op_e        op,
    output pmode_e     pm_eff,
    output logic       pm_bad,
    output logic       prec_sel,
    output logic       res_sel
);

    logic [7:0] mode_r;

    // Mode word storage: software write, or automatic return to idle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_r <= 8'h00;
        end else if (wr_en) begin
            mode_r <= {1'b0, wr_data[6:0]};
        end else if (oneshot_done) begin
            mode_r[2:0] <= OP_IDLE;
        end
    end

    // Field decode; undefined power code runs as normal.
    always_comb begin
        op       = op_e'(mode_r[2:0]);
        pm_eff   = (mode_r[4:3] == 2'b11) ? PM_NORMAL : pmode_e'(mode_r[4:3]);
        prec_sel = mode_r[5];
        res_sel  = mode_r[6];
        pm_bad   = wr_en && (wr_data[4:3] == 2'b11);
        mode_q   = mode_r;
    end

    assert_reserved_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !mode_q[7]);

    assert_auto_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (oneshot_done && !wr_en) |=> (mode_q[2:0] == OP_IDLE));

endmodule

// File: rtl/adc_settle_counter.sv
`timescale 1ns/1ps
// Module: adc_settle_counter
// Counts converter-cycle strobes for the running operation and flags the
// strobe that completes the settle window. The count saturates, so
// continuous mode flags every strobe after settling. Assumes chop is held
// steady during a count; a clear (mode write) restarts from zero.
module adc_settle_counter
    import adc_seq_pkg::*;
#(
    parameter int CNT_W = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic run,
    input  logic chop,
    input  op_e  op,
    input  logic cyc_done,
    output logic hit
);

    localparam logic [CNT_W-1:0] BASE_CHOP = CNT_W'(3);
    localparam logic [CNT_W-1:0] BASE_PLAIN = CNT_W'(2);
    localparam logic [CNT_W-1:0] ZERO_CYC = CNT_W'(3);
    localparam logic [CNT_W-1:0] MAX_CNT = CNT_W'(5);

    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] base;
    logic [CNT_W-1:0] tgt;
    logic [CNT_W-1:0] tgt_m1;
    logic             settled;

    // Settle window length for the current operation and chop setting.
    always_comb begin
        base = chop ? BASE_CHOP : BASE_PLAIN;
        unique case (op)
            OP_SGAIN: tgt = base << 1;
            OP_ZERO:  tgt = ZERO_CYC;
            default:  tgt = base;
        endcase
        tgt_m1  = tgt - 1'b1;
        settled = (cnt >= tgt_m1);
        hit     = run && cyc_done && !clear && settled;
    end

    // Strobe counter, cleared by writes and when no operation runs.
    always_ff @(posedge clk) begin
        if (!rst_n || clear || !run) begin
            cnt <= '0;
        end else if (cyc_done && !settled) begin
            cnt <= cnt + 1'b1;
        end
    end

    assert_cnt_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= MAX_CNT);

    assert_clear_restarts_R11: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> (cnt == '0));

    assert_no_hit_idle_R13: assert property (@(posedge clk) disable iff (!rst_n)
        !run |-> !hit);

endmodule

// File: rtl/adc_cal_store.sv
`timescale 1ns/1ps
// Module: adc_cal_store
// Per-channel offset and gain coefficient registers. A load pulse writes
// the data word into every channel whose enable bit is set. Assumes the
// offset and gain loads are never raised in the same cycle.
module adc_cal_store #(
    parameter int              NCH      = 2,
    parameter int              DW       = 16,
    parameter logic [DW-1:0]   GAIN_RST = 16'h8000
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                load_off,
    input  logic                load_gain,
    input  logic [NCH-1:0]      chan_en,
    input  logic [DW-1:0]       data,
    output logic [NCH*DW-1:0]   off_flat,
    output logic [NCH*DW-1:0]   gain_flat
);

    for (genvar ch = 0; ch < NCH; ch++) begin : g_chan
        logic [DW-1:0] off_r;
        logic [DW-1:0] gain_r;

        // Offset coefficient for this channel.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                off_r <= '0;
            end else if (load_off && chan_en[ch]) begin
                off_r <= data;
            end
        end

        // Gain coefficient for this channel.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                gain_r <= GAIN_RST;
            end else if (load_gain && chan_en[ch]) begin
                gain_r <= data;
            end
        end

        assign off_flat[ch*DW +: DW]  = off_r;
        assign gain_flat[ch*DW +: DW] = gain_r;
    end

    assert_single_load_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !(load_off && load_gain));

endmodule

// File: rtl/adc_mode_sequencer.sv
`timescale 1ns/1ps
// Module: adc_mode_sequencer (top)
// Sequences the ADC operation selected by the mode word. It counts
// settle strobes, routes the settled word to the result or calibration
// registers, drives the power, reference and gain controls, and keeps
// read-to-clear status flags. Assumes cyc_done is a single-cycle pulse.
module adc_mode_sequencer
    import adc_seq_pkg::*;
#(
    parameter int            NCH      = 2,
    parameter int            DW       = 16,
    parameter int            CNT_W    = 3,
    parameter logic [DW-1:0] GAIN_RST = 16'h8000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [7:0]        wr_data,
    input  logic              rd_en,
    input  logic              chop_en,
    input  logic [NCH-1:0]    chan_en,
    input  logic              cyc_done,
    input  logic [DW-1:0]     cyc_data,
    output logic [7:0]        mode_q,
    output logic [2:0]        status_q,
    output logic              pwr_on,
    output logic              ref_en,
    output logic              conv_rst,
    output logic              prec_ref_en,
    output logic              lp_ref_en,
    output logic              res_sel,
    output logic [1:0]        gain_fix,
    output logic              busy,
    output logic              drdy_pulse,
    output logic [DW-1:0]     result_q,
    output logic [NCH*DW-1:0] off_q,
    output logic [NCH*DW-1:0] gain_q
);

    op_e    op;
    pmode_e pm_eff;
    logic   pm_bad;
    logic   prec_sel;
    logic   run;
    logic   hit;
    logic   oneshot_done;
    logic   load_res;
    logic   load_off;
    logic   load_gain;
    logic   conv_rdy;
    logic   cal_rdy;
    logic   pm_err;

    adc_mode_reg u_mode (
        .clk          (clk),
        .rst_n        (rst_n),
        .wr_en        (wr_en),
        .wr_data      (wr_data),
        .oneshot_done (oneshot_done),
        .mode_q       (mode_q),
        .op           (op),
        .pm_eff       (pm_eff),
        .pm_bad       (pm_bad),
        .prec_sel     (prec_sel),
        .res_sel      (res_sel)
    );

    adc_settle_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear    (wr_en),
        .run      (run),
        .chop     (chop_en),
        .op       (op),
        .cyc_done (cyc_done),
        .hit      (hit)
    );

    adc_cal_store #(.NCH(NCH), .DW(DW), .GAIN_RST(GAIN_RST)) u_cal (
        .clk       (clk),
        .rst_n     (rst_n),
        .load_off  (load_off),
        .load_gain (load_gain),
        .chan_en   (chan_en),
        .data      (cyc_data),
        .off_flat  (off_q),
        .gain_flat (gain_q)
    );

    // Route the settling strobe to its destination by operation.
    always_comb begin
        run          = op_active(op);
        load_res     = hit && ((op == OP_SINGLE) || (op == OP_CONT));
        load_off     = hit && ((op == OP_SOFF) || (op == OP_ZERO));
        load_gain    = hit && ((op == OP_SGAIN) || (op == OP_FULL));
        oneshot_done = hit && (op != OP_CONT);
    end

    // Analog control outputs from the operation and power fields.
    always_comb begin
        pwr_on      = (op != OP_PWRDN);
        ref_en      = (op != OP_PWRDN);
        conv_rst    = !run;
        busy        = run;
        gain_fix    = pm_eff;
        prec_ref_en = ref_en && ((pm_eff == PM_NORMAL) || prec_sel);
        lp_ref_en   = ref_en && (pm_eff != PM_NORMAL) && !prec_sel;
    end

    // Conversion result register and data-ready pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            result_q   <= '0;
            drdy_pulse <= 1'b0;
        end else begin
            drdy_pulse <= load_res;
            if (load_res) begin
                result_q <= cyc_data;
            end
        end
    end

    // Status flags: set by events, cleared by a read, set wins.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            conv_rdy <= 1'b0;
            cal_rdy  <= 1'b0;
            pm_err   <= 1'b0;
        end else begin
            conv_rdy <= (conv_rdy && !rd_en) || load_res || load_off || load_gain;
            cal_rdy  <= (cal_rdy && !rd_en) || load_off || load_gain;
            pm_err   <= (pm_err && !rd_en) || pm_bad;
        end
    end

    assign status_q = {pm_err, cal_rdy, conv_rdy};

    assert_cal_sets_both_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cal_rdy) |-> conv_rdy);

    assert_one_route_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({load_res, load_off, load_gain}));

    assert_read_clears_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && !hit && !pm_bad) |=> (status_q == 3'b000));

    assert_drdy_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
        drdy_pulse |-> ($past(op) == OP_SINGLE || $past(op) == OP_CONT));

    assert_cont_holds_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_CONT && !wr_en) |=> (op == OP_CONT));

endmodule

// File: tb/adc_mode_sequencer_bench.sv
`timescale 1ns/1ps
module adc_mode_sequencer_bench;

    localparam int NCH = 2;
    localparam int DW  = 16;
    localparam logic [DW-1:0] GRST = 16'h8000;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              wr_en = 1'b0;
    logic [7:0]        wr_data = 8'h00;
    logic              rd_en = 1'b0;
    logic              chop_en = 1'b0;
    logic [NCH-1:0]    chan_en = '0;
    logic              cyc_done = 1'b0;
    logic [DW-1:0]     cyc_data = '0;
    logic [7:0]        mode_q;
    logic [2:0]        status_q;
    logic              pwr_on, ref_en, conv_rst, prec_ref_en, lp_ref_en, res_sel;
    logic [1:0]        gain_fix;
    logic              busy, drdy_pulse;
    logic [DW-1:0]     result_q;
    logic [NCH*DW-1:0] off_q, gain_q;

    adc_mode_sequencer #(.NCH(NCH), .DW(DW), .GAIN_RST(GRST)) u_adc_mode_sequencer (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .rd_en(rd_en),
        .chop_en(chop_en), .chan_en(chan_en), .cyc_done(cyc_done), .cyc_data(cyc_data),
        .mode_q(mode_q), .status_q(status_q), .pwr_on(pwr_on), .ref_en(ref_en),
        .conv_rst(conv_rst), .prec_ref_en(prec_ref_en), .lp_ref_en(lp_ref_en),
        .res_sel(res_sel), .gain_fix(gain_fix), .busy(busy), .drdy_pulse(drdy_pulse),
        .result_q(result_q), .off_q(off_q), .gain_q(gain_q)
    );

    always #10 clk = ~clk;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    // Reference model state
    logic [7:0]    mode_m;
    logic [DW-1:0] res_m;
    logic [DW-1:0] off_m  [NCH];
    logic [DW-1:0] gain_m [NCH];
    logic          conv_f, cal_f, err_f, drdy_m;

    function automatic int exp_cycles(logic [2:0] op, logic chop);
        int base = chop ? 3 : 2;
        if (op == 3'b110) return 3;
        if (op == 3'b101) return 2 * base;
        return base;
    endfunction

    function automatic logic [1:0] exp_pm(logic [7:0] m);
        return (m[4:3] == 2'b11) ? 2'b00 : m[4:3];
    endfunction

    task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic check_all(string req);
        logic [2:0] op = mode_m[2:0];
        logic act = (op != 3'b000) && (op != 3'b011);
        logic on  = (op != 3'b000);
        logic [1:0] pm = exp_pm(mode_m);
        logic [NCH*DW-1:0] of, gf;
        for (int c = 0; c < NCH; c++) begin
            of[c*DW +: DW] = off_m[c];
            gf[c*DW +: DW] = gain_m[c];
        end
        chk({req, " mode"}, 64'(mode_q), 64'(mode_m));
        chk({req, " R3 ctrl"}, 64'({pwr_on, ref_en, conv_rst, busy}), 64'({on, on, !act, act}));
        chk({req, " R10 pwr"}, 64'({gain_fix, prec_ref_en, lp_ref_en, res_sel}),
            64'({pm, on && (pm == 2'b00 || mode_m[5]), on && pm != 2'b00 && !mode_m[5], mode_m[6]}));
        chk({req, " result"}, 64'(result_q), 64'(res_m));
        chk({req, " offsets"}, 64'(off_q), 64'(of));
        chk({req, " gains"}, 64'(gain_q), 64'(gf));
        chk({req, " status"}, 64'(status_q), 64'({err_f, cal_f, conv_f}));
        chk({req, " drdy"}, 64'(drdy_pulse), 64'(drdy_m));
    endtask

    task automatic do_write(logic [7:0] m);
        wr_en = 1'b1;
        wr_data = m;
        tick();
        wr_en = 1'b0;
        mode_m = {1'b0, m[6:0]};
        if (m[4:3] == 2'b11) err_f = 1'b1;
        drdy_m = 1'b0;
        check_all("R2 write");
    endtask

    task automatic strobe(logic [DW-1:0] d);
        cyc_done = 1'b1;
        cyc_data = d;
        tick();
        cyc_done = 1'b0;
    endtask

    task automatic read_status();
        rd_en = 1'b1;
        #1;
        chk("R12 read view", 64'(status_q), 64'({err_f, cal_f, conv_f}));
        tick();
        rd_en = 1'b0;
        conv_f = 1'b0; cal_f = 1'b0; err_f = 1'b0; drdy_m = 1'b0;
        check_all("R12 cleared");
    endtask

    task automatic maybe_gap();
        if ($urandom_range(0, 2) == 0) begin
            tick();
            drdy_m = 1'b0;
            check_all("gap");
        end
    endtask

    task automatic run_op(logic [7:0] m, logic chop, logic [NCH-1:0] ch);
        logic [2:0] op = m[2:0];
        int n;
        string req;
        chop_en = chop;
        chan_en = ch;
        do_write(m);
        n = exp_cycles(op, chop);
        case (op)
            3'b000, 3'b011: begin
                for (int i = 0; i < 2; i++) begin
                    strobe(DW'($urandom));
                    drdy_m = 1'b0;
                    check_all("R13 ignored");
                end
            end
            3'b001: begin
                for (int i = 0; i < n + 2; i++) begin
                    logic [DW-1:0] d = DW'($urandom);
                    maybe_gap();
                    strobe(d);
                    if (i >= n - 1) begin
                        res_m = d; conv_f = 1'b1; drdy_m = 1'b1;
                    end else begin
                        drdy_m = 1'b0;
                    end
                    check_all("R5 continuous");
                end
            end
            default: begin
                case (op)
                    3'b010:  req = "R4 single";
                    3'b100:  req = "R6 self-offset";
                    3'b101:  req = "R7 self-gain";
                    3'b110:  req = "R8 zero-scale";
                    default: req = "R9 full-scale";
                endcase
                for (int i = 0; i < n; i++) begin
                    logic [DW-1:0] d = DW'($urandom);
                    maybe_gap();
                    strobe(d);
                    drdy_m = 1'b0;
                    if (i == n - 1) begin
                        mode_m[2:0] = 3'b011;
                        conv_f = 1'b1;
                        if (op == 3'b010) begin
                            res_m = d; drdy_m = 1'b1;
                        end else begin
                            cal_f = 1'b1;
                            for (int c = 0; c < NCH; c++) begin
                                if (ch[c]) begin
                                    if (op == 3'b100 || op == 3'b110) off_m[c] = d;
                                    else gain_m[c] = d;
                                end
                            end
                        end
                    end
                    check_all(req);
                end
            end
        endcase
        tick();
        drdy_m = 1'b0;
        check_all("settle");
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        mode_m = 8'h00; res_m = '0; conv_f = 0; cal_f = 0; err_f = 0; drdy_m = 0;
        for (int c = 0; c < NCH; c++) begin
            off_m[c] = '0;
            gain_m[c] = GRST;
        end
        repeat (3) tick();
        rst_n = 1'b1;
        tick();
        check_all("R1 reset");

        // R13: strobes in power-down change nothing
        strobe(16'hABCD);
        check_all("R13 power-down");

        // Directed: each operation with both chop settings
        for (int op = 0; op < 8; op++) begin
            for (int cp = 0; cp < 2; cp++) begin
                run_op(8'(op), cp[0], 2'b11);
                read_status();
            end
        end

        // R11: abort a single conversion mid-count, then self-gain from zero
        chop_en = 1'b1;
        do_write(8'h02);
        strobe(16'h1111);
        check_all("R11 partial");
        strobe(16'h2222);
        check_all("R11 partial");
        run_op(8'h05, 1'b1, 2'b01);
        read_status();

        // R10: undefined power code acts as normal and raises the error flag
        run_op(8'h1B, 1'b0, 2'b00);
        read_status();
        run_op(8'hAA, 1'b0, 2'b10);
        read_status();

        // R8: zero-scale ignores chop, channel mask honoured
        run_op(8'h06, 1'b0, 2'b10);
        run_op(8'h06, 1'b1, 2'b01);
        read_status();

        // Random mix
        for (int it = 0; it < 80; it++) begin
            run_op(8'($urandom), 1'($urandom), NCH'($urandom));
            if ($urandom_range(0, 1) == 0) read_status();
        end
        read_status();

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule